// File: doc/BRIEF.md
# Program Counter Fetch Unit with Shared Memory Bus

This block holds the processor's program counter and presents it as the instruction address on a memory bus. That bus is shared with a second master, the data memory-access unit. The controller's state code is the only control input. In the three data-memory states the block releases both of its bus outputs to high impedance so that the other master can drive them. In every other state it drives the read strobe high and puts the current PC on the address lines.

The PC register changes only on a clock edge that ends a PC-update state. On that edge it loads either the branch target or the incremented PC. A synchronous reset loads the start address 16'h3000. The next-PC output always shows the register plus one. It stays driven even while the bus is released, so neighbouring logic can use it at any time.

The state code is a 3-bit input with this encoding:

| Code | State |
|------|-------|
| 0 | fetch |
| 1 | decode |
| 2 | execute |
| 3 | write-back |
| 4 | data read |
| 5 | data write |
| 6 | indirect address read |
| 7 | PC update |

Top module: `fetch_unit`

## Requirements
- R1: A high `rst` at a rising edge loads the PC with 16'h3000, whatever the state code and branch inputs are in that cycle.
- R2: `npc` always equals the PC register plus one, in every state including the released ones.
- R3: At the edge that ends state code 7 with `br_taken` low, the PC advances by one.
- R4: At the edge that ends state code 7 with `br_taken` high, the PC loads `taddr`.
- R5: In state codes 0 to 6 the PC holds its value, and `br_taken` and `taddr` have no effect on it.
- R6: In state codes 0, 1, 2, 3 and 7 the `rd` output is driven to 1.
- R7: In state codes 4, 5 and 6 both `rd` and `pc` are high impedance, so the other master's values appear on the bus.
- R8: In the state codes that own the bus, `pc` shows the PC register.
- R9: PC arithmetic wraps modulo 2^16: incrementing 16'hFFFF gives 16'h0000, and `npc` at 16'hFFFF is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| state | input | 3 | Controller state code |
| taddr | input | 16 | Branch target address |
| br_taken | input | 1 | Branch taken; selects `taddr` in the PC-update state |
| rd | output | 1 | Read strobe; 1 when owning the bus, high impedance otherwise |
| pc | output | 16 | Instruction address; high impedance when the bus is released |
| npc | output | 16 | PC plus one, always driven |

## Verification
The `rd` and `pc` outputs depend combinationally on the state code, so they are due in the same cycle the state is applied. The bench applies inputs just after a falling edge and samples them 2 ns later. A PC change is due only after the rising edge that ends a PC-update or reset cycle. The behavioural model therefore updates its PC at that rising edge, and each value it predicts is compared in the following cycle. In the released states the bench drives the bus itself as the other master, with a distinct pattern. A wrong drive from the block then shows up as a mismatch on the bus.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_WBACK  = 3'd3,
    ST_MEM_RD = 3'd4,
    ST_MEM_WR = 3'd5,
    ST_IND_RD = 3'd6,
    ST_PC_UPD = 3'd7
  } ctrl_state_e;
endpackage

// File: rtl/fetch_state_dec.sv
`timescale 1ns/1ps
module fetch_state_dec
  import fetch_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output logic               bus_grant,
  output logic               pc_step
);
  always_comb begin
    bus_grant = 1'b1;
    pc_step   = 1'b0;
    case (state)
      ST_MEM_RD, ST_MEM_WR, ST_IND_RD: bus_grant = 1'b0;
      ST_PC_UPD:                       pc_step   = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fetch_pc_reg.sv
`timescale 1ns/1ps
module fetch_pc_reg #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] taddr,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_inc
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc_next;

  assign pc_inc  = pc_q + ONE;
  assign pc_next = br_taken ? taddr : pc_inc;

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= RESET_PC;
    else if (step) pc_q <= pc_next;
  end
endmodule

// File: rtl/fetch_bus_drv.sv
`timescale 1ns/1ps
module fetch_bus_drv #(
  parameter int ADDR_W = 16
) (
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o
);
  assign rd_o   = oe ? 1'b1 : 1'bz;
  assign addr_o = oe ? addr_in : {ADDR_W{1'bz}};
endmodule

// File: rtl/fetch_unit.sv
`timescale 1ns/1ps
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h3000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state,
  input  logic [ADDR_W-1:0]  taddr,
  input  logic               br_taken,
  output logic               rd,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  npc
);
  logic              bus_oe;
  logic              pc_step;
  logic [ADDR_W-1:0] pc_q;

  fetch_state_dec u_dec (
    .state     (state),
    .bus_grant (bus_oe),
    .pc_step   (pc_step)
  );

  fetch_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .step     (pc_step),
    .br_taken (br_taken),
    .taddr    (taddr),
    .pc_q     (pc_q),
    .pc_inc   (npc)
  );

  fetch_bus_drv #(.ADDR_W(ADDR_W)) u_drv (
    .oe      (bus_oe),
    .addr_in (pc_q),
    .rd_o    (rd),
    .addr_o  (pc)
  );
endmodule

// File: rtl/fetch_unit_chk.sv
`timescale 1ns/1ps
module fetch_unit_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h3000
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        state,
  input logic              br_taken,
  input logic [ADDR_W-1:0] taddr,
  input logic [ADDR_W-1:0] npc,
  input logic [ADDR_W-1:0] pc_q,
  input logic              bus_oe
);
  logic armed = 1'b0;
  logic rst_seen = 1'b0;
  logic in_mem;
  logic in_upd;

  assign in_mem = (state == 3'd4) || (state == 3'd5) || (state == 3'd6);
  assign in_upd = (state == 3'd7);

  always_ff @(posedge clk) begin
    armed    <= !rst;
    rst_seen <= rst;
  end

  // R1: a cycle with reset leaves the start address in the register
  always_ff @(posedge clk)
    if (rst_seen) p_reset_start_r1: assert (pc_q == RESET_PC);

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && in_upd && !br_taken) |=> (npc == $past(npc) + 1'b1));

  p_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && in_upd && br_taken) |=> (pc_q == $past(taddr)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && !in_upd) |=> $stable(npc));

  p_own_bus_r6: assert property (@(posedge clk) disable iff (rst)
    !in_mem |-> bus_oe);

  p_release_bus_r7: assert property (@(posedge clk) disable iff (rst)
    in_mem |-> !bus_oe);
endmodule

bind fetch_unit fetch_unit_chk #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .state    (state),
  .br_taken (br_taken),
  .taddr    (taddr),
  .npc      (npc),
  .pc_q     (pc_q),
  .bus_oe   (bus_oe)
);

// File: tb/fetch_unit_test.sv
`timescale 1ns/1ps
module fetch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  state = 3'd0;
  logic [15:0] taddr = 16'h0;
  logic        br_taken = 1'b0;
  wire         rd_bus;
  wire  [15:0] pc_bus;
  logic [15:0] npc;

  int total = 0;
  int bad = 0;
  logic        ref_ok = 1'b0;
  logic [15:0] ref_pc = 16'h0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  // other bus master: drives a marker pattern in its own states
  logic other_en;
  assign other_en = (state == 3'd4) || (state == 3'd5) || (state == 3'd6);
  assign rd_bus = other_en ? 1'b0 : 1'bz;
  assign pc_bus = other_en ? 16'hA5A5 : 16'hzzzz;

  fetch_unit uut (
    .clk(clk), .rst(rst), .state(state), .taddr(taddr),
    .br_taken(br_taken), .rd(rd_bus), .pc(pc_bus), .npc(npc)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [2:0] s, input logic b, input logic [15:0] t);
    rst = r; state = s; br_taken = b; taddr = t;
    #2;
    if (ref_ok) begin
      chk(((ref_pc == 16'hFFFF) ? "R9 npc wrap" : "R2 npc"), npc, ref_pc + 16'd1);
      if (other_en) begin
        chk("R7 rd released", {15'd0, rd_bus}, 16'h0000);
        chk("R7 pc released", pc_bus, 16'hA5A5);
      end else begin
        chk("R6 rd driven", {15'd0, rd_bus}, 16'h0001);
        chk("R8 pc driven", pc_bus, ref_pc);
      end
    end
    @(posedge clk);
    if (r) begin
      ref_pc = 16'h3000; ref_ok = 1'b1;        // R1
    end else if (s == 3'd7 && ref_ok) begin
      ref_pc = b ? t : ref_pc + 16'd1;         // R3 R4 R9
    end                                          // R5: otherwise hold
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset dominates an update state with a branch pending
    step(1'b1, 3'd7, 1'b1, 16'h1234);
    step(1'b1, 3'd7, 1'b1, 16'h1234);
    step(1'b0, 3'd0, 1'b0, 16'h0);
    chk("R1 reset pc", pc_bus, 16'h3000);
    // R3 R5: instruction-like walks with noisy branch inputs outside update
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 3'd0, 1'b1, 16'hBEEF);
      step(1'b0, 3'd1, 1'b1, 16'hBEEF);
      step(1'b0, 3'd2, 1'b1, 16'hBEEF);
      step(1'b0, 3'd4, 1'b1, 16'hBEEF);
      step(1'b0, 3'd3, 1'b1, 16'hBEEF);
      step(1'b0, 3'd7, 1'b0, 16'hBEEF);
    end
    step(1'b0, 3'd0, 1'b0, 16'h0);
    chk("R3 step count", pc_bus, 16'h3006);
    // R4 then R9: branch near the top, then wrap
    step(1'b0, 3'd7, 1'b1, 16'hFFFE);
    step(1'b0, 3'd0, 1'b0, 16'h0);
    chk("R4 branch target", pc_bus, 16'hFFFE);
    step(1'b0, 3'd7, 1'b0, 16'h0);
    step(1'b0, 3'd1, 1'b0, 16'h0);
    chk("R9 at top", npc, 16'h0000);
    step(1'b0, 3'd7, 1'b0, 16'h0);
    step(1'b0, 3'd2, 1'b0, 16'h0);
    chk("R9 wrapped", pc_bus, 16'h0000);
    // all states with mixed branch patterns
    for (int i = 0; i < 24; i++)
      for (int s = 0; s < 8; s++)
        step(1'b0, 3'(s), i[0] ^ s[1], 16'(i * 16'h1111 + s));
    // R1: reset issued inside a released state
    step(1'b0, 3'd5, 1'b0, 16'h0);
    step(1'b1, 3'd5, 1'b1, 16'h7777);
    step(1'b0, 3'd6, 1'b0, 16'h0);
    step(1'b0, 3'd0, 1'b0, 16'h0);
    chk("R1 reset in mem state", pc_bus, 16'h3000);
    // R5: long stretch without update
    for (int i = 0; i < 10; i++) step(1'b0, 3'(i % 7), 1'b1, 16'(i));
    step(1'b0, 3'd3, 1'b0, 16'h0);
    chk("R5 hold", pc_bus, 16'h3000);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule